// File: doc/BRIEF.md
# Pointer-Relative Short Load/Store Unit

This unit carries out the compact 16-bit load and store forms. Each of these forms addresses memory at a fixed base pointer plus a small unsigned offset. The unit decodes the instruction word and scales the encoded offset by the access size. It adds the offset to the base pointer and drives a byte, halfword or word request onto a 32-bit memory port with per-byte enables.

Loads take their data from the memory port in the same cycle as the request. The selected lane is sign- or zero-extended, and the 32-bit result is presented one clock later with a valid strobe. Stores copy the low byte, low halfword or full word of the store-source value onto every matching lane. The byte enables pick out the lane that is written.

Any word that matches none of the short forms raises an illegal-operation flag for that cycle, and no memory request is made. The base pointer and the store source come in as plain values, because the register file sits outside this unit.

Top module: `sld_unit`

## Requirements
- R1: The request address is `base_ptr` plus the decoded offset, always zero-extended to 32 bits. The 32-bit sum wraps, and no sign is taken from the offset.
- R2: When `op_word[10:7]` = 0110, the unit issues a signed byte load with offset `op_word[6:0]`. The loaded byte is sign-extended into `ld_data`.
- R3: When `op_word[10:4]` = 0000110, the unit issues an unsigned byte load with offset `op_word[3:0]`. The loaded byte is zero-extended.
- R4: When `op_word[10:7]` = 1000, the unit issues a signed halfword load with offset `op_word[6:0]` times 2. The halfword is sign-extended.
- R5: When `op_word[10:4]` = 0000111, the unit issues an unsigned halfword load with offset `op_word[3:0]` times 2. The halfword is zero-extended.
- R6: When `op_word[10:7]` = 1010, the unit makes a word access with offset `op_word[6:1]` times 4. `op_word[0]` = 0 selects a load, and 1 selects a store.
- R7: `op_word[10:7]` = 0111 is a byte store with offset `op_word[6:0]`. `op_word[10:7]` = 1001 is a halfword store with offset `op_word[6:0]` times 2. On a store, `mem_wdata` repeats the low byte, low halfword or full word of `st_src` across every lane.
- R8: The byte enables are little-endian. A byte access sets bit `addr[1:0]`. A halfword access sets bits 1:0 when `addr[1]` = 0 and bits 3:2 when `addr[1]` = 1. A word access sets all four bits. A load takes its data from the same lane.
- R9: A valid word that matches no form sets `illegal_op` in that cycle and leaves `mem_req` low.
- R10: `ld_valid` is high exactly in the cycle after a load request, with `ld_data` holding the extended result. A store never raises `ld_valid`.
- R11: After reset, `ld_valid` is 0 and `ld_data` is 0.
- R12: While `op_valid` is low, `mem_req` and `illegal_op` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word is present this cycle |
| op_word | input | 16 | Short-form instruction |
| base_ptr | input | 32 | Base pointer value |
| st_src | input | 32 | Store-source register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables, bit n = bits 8n+7:8n |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read data, same cycle as the request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| illegal_op | output | 1 | Word matches no short form |

## Verification
The hardest cases to reach from the ports are those where the lane choice and the extension interact. Examples are a signed byte from the top lane, or a halfword from the upper half with its sign bit set. These depend on both the base pointer's low bits and the largest encoded offset. The directed scenarios therefore pair unaligned base pointers with the maximum offset of each form. The read data is loaded with a set top bit in the selected lane and different values elsewhere. A wrong lane or a wrong extension then shows up in `ld_data`.

// File: rtl/sld_pkg.sv
package sld_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int INSN_W = 16;
    localparam int LANES  = DATA_W / 8;
    localparam int OFS_W  = $clog2(LANES);
    localparam int DISP_W = 8;

    typedef enum logic [1:0] {ACC_BYTE, ACC_HALF, ACC_WORD} acc_size_e;

    typedef struct packed {
        logic              legal;
        logic              store;
        logic              sign;
        acc_size_e         size;
        logic [DISP_W-1:0] disp;
    } sld_op_t;

    function automatic logic [LANES-1:0] lane_enables(acc_size_e sz, logic [OFS_W-1:0] ofs);
        logic [LANES-1:0] be;
        case (sz)
            ACC_BYTE: be = LANES'(1) << ofs;
            ACC_HALF: be = LANES'(3) << {ofs[OFS_W-1:1], 1'b0};
            default:  be = '1;
        endcase
        return be;
    endfunction
endpackage

// File: rtl/sld_decode.sv
module sld_decode
    import sld_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output sld_op_t           op
);
    always_comb begin
        op = '0;
        op.size = ACC_BYTE;
        unique casez (insn[10:7])
            4'b0110: begin op.legal = 1'b1; op.sign = 1'b1; op.size = ACC_BYTE;
                           op.disp = {1'b0, insn[6:0]}; end
            4'b0111: begin op.legal = 1'b1; op.store = 1'b1; op.size = ACC_BYTE;
                           op.disp = {1'b0, insn[6:0]}; end
            4'b1000: begin op.legal = 1'b1; op.sign = 1'b1; op.size = ACC_HALF;
                           op.disp = {insn[6:0], 1'b0}; end
            4'b1001: begin op.legal = 1'b1; op.store = 1'b1; op.size = ACC_HALF;
                           op.disp = {insn[6:0], 1'b0}; end
            4'b1010: begin op.legal = 1'b1; op.store = insn[0]; op.size = ACC_WORD;
                           op.disp = {insn[6:1], 2'b00}; end
            4'b0000: begin
                if (insn[6:4] == 3'b110) begin
                    op.legal = 1'b1; op.size = ACC_BYTE;
                    op.disp = {4'b0, insn[3:0]};
                end else if (insn[6:4] == 3'b111) begin
                    op.legal = 1'b1; op.size = ACC_HALF;
                    op.disp = {3'b0, insn[3:0], 1'b0};
                end
            end
            default: op = op;
        endcase
    end
endmodule

// File: rtl/sld_agen.sv
module sld_agen
    import sld_pkg::*;
(
    input  sld_op_t           op,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] src,
    output logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    assign addr = base + ADDR_W'(op.disp);
    assign be   = lane_enables(op.size, addr[OFS_W-1:0]);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            case (op.size)
                ACC_BYTE: wdata[g*8 +: 8] = src[7:0];
                ACC_HALF: wdata[g*8 +: 8] = src[(g % 2)*8 +: 8];
                default:  wdata[g*8 +: 8] = src[g*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/sld_extend.sv
module sld_extend
    import sld_pkg::*;
(
    input  sld_op_t           op,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] b_shift, h_shift;

    assign b_shift = rdata >> {ofs, 3'b000};
    assign h_shift = rdata >> {ofs[OFS_W-1:1], 4'b0000};

    always_comb begin
        case (op.size)
            ACC_BYTE: result = op.sign ? {{(DATA_W-8){b_shift[7]}}, b_shift[7:0]}
                                       : {{(DATA_W-8){1'b0}}, b_shift[7:0]};
            ACC_HALF: result = op.sign ? {{(DATA_W-16){h_shift[15]}}, h_shift[15:0]}
                                       : {{(DATA_W-16){1'b0}}, h_shift[15:0]};
            default:  result = rdata;
        endcase
    end
endmodule

// File: rtl/sld_unit.sv
module sld_unit
    import sld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [INSN_W-1:0] op_word,
    input  logic [ADDR_W-1:0] base_ptr,
    input  logic [DATA_W-1:0] st_src,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              illegal_op
);
    sld_op_t           op;
    logic [LANES-1:0]  be_raw;
    logic [DATA_W-1:0] ext_val;

    sld_decode u_dec (.insn(op_word), .op(op));

    sld_agen u_agen (
        .op(op), .base(base_ptr), .src(st_src),
        .addr(mem_addr), .be(be_raw), .wdata(mem_wdata)
    );

    sld_extend u_ext (
        .op(op), .ofs(mem_addr[OFS_W-1:0]), .rdata(mem_rdata), .result(ext_val)
    );

    assign mem_req    = op_valid & op.legal;
    assign mem_we     = mem_req & op.store;
    assign mem_be     = mem_req ? be_raw : '0;
    assign illegal_op = op_valid & ~op.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= mem_req & ~op.store;
            if (mem_req & ~op.store)
                ld_data <= ext_val;
        end
    end
endmodule

// File: rtl/sld_unit_chk.sv
module sld_unit_chk
    import sld_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              illegal_op,
    input logic              mem_req,
    input logic              mem_we,
    input logic [LANES-1:0]  mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              ld_valid
);
    a_r9_illegal_no_req: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> !mem_req);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!mem_req && !illegal_op));

    a_r10_load_result: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> ld_valid);

    a_r10_store_silent: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> !ld_valid);

    a_r8_lane_count: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                     $countones(mem_be) == 4));

    a_r7_byte_repeat: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && $countones(mem_be) == 1) |->
            (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[15:8] == mem_wdata[7:0]));

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> !ld_valid);
endmodule

bind sld_unit sld_unit_chk u_chk (.*);

// File: tb/sld_unit_test.sv
module sld_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [15:0] op_word;
    logic [31:0] base_ptr, st_src, mem_rdata;
    logic        mem_req, mem_we, ld_valid, illegal_op;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sld_unit uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one legal access; check the request, then the load result.
    task automatic run_op(string req, logic [15:0] w, logic [31:0] base,
                          logic [31:0] src, logic [31:0] rd, logic [31:0] e_addr,
                          logic [3:0] e_be, logic e_we, logic [31:0] e_wd,
                          logic [31:0] e_ld);
        @(negedge clk);
        op_valid = 1'b1; op_word = w; base_ptr = base; st_src = src; mem_rdata = rd;
        #1;
        chk({req, " req"}, 32'(mem_req), 32'd1);
        chk({req, " addr"}, mem_addr, e_addr);
        chk({req, " be"}, 32'(mem_be), 32'(e_be));
        chk({req, " we"}, 32'(mem_we), 32'(e_we));
        chk({req, " illegal"}, 32'(illegal_op), 32'd0);
        if (e_we) chk({req, " wdata"}, mem_wdata, e_wd);
        @(negedge clk);
        op_valid = 1'b0;
        chk({req, " R10 ld_valid"}, 32'(ld_valid), 32'(!e_we));
        if (!e_we) chk({req, " ld_data"}, ld_data, e_ld);
    endtask

    task automatic t_reset;
        chk("R11 ld_valid", 32'(ld_valid), 32'd0);
        chk("R11 ld_data", ld_data, 32'd0);
        chk("R12 mem_req", 32'(mem_req), 32'd0);
    endtask

    task automatic t_byte_signed;   // R2 R8 R1
        run_op("R2", {5'd3, 4'b0110, 7'd5}, 32'h1000_0002, 32'h0, 32'h8011_2233,
               32'h1000_0007, 4'b1000, 1'b0, 32'h0, 32'hFFFF_FF80);
        run_op("R2 pos", {5'd3, 4'b0110, 7'd0}, 32'h1000_0001, 32'h0, 32'h8011_7F33,
               32'h1000_0001, 4'b0010, 1'b0, 32'h0, 32'h0000_007F);
    endtask

    task automatic t_byte_unsigned; // R3
        run_op("R3", {5'd0, 7'b0000110, 4'hF}, 32'h2000_0000, 32'h0, 32'h9A00_0000,
               32'h2000_000F, 4'b1000, 1'b0, 32'h0, 32'h0000_009A);
    endtask

    task automatic t_half_signed;   // R4
        run_op("R4", {5'd0, 4'b1000, 7'h7F}, 32'h0000_0100, 32'h0, 32'hC0DE_1234,
               32'h0000_01FE, 4'b1100, 1'b0, 32'h0, 32'hFFFF_C0DE);
    endtask

    task automatic t_half_unsigned; // R5
        run_op("R5", {5'd0, 7'b0000111, 4'hF}, 32'h0000_0300, 32'h0, 32'h8001_0000,
               32'h0000_031E, 4'b1100, 1'b0, 32'h0, 32'h0000_8001);
    endtask

    task automatic t_word;          // R6
        run_op("R6 load", {5'd0, 4'b1010, 6'h3F, 1'b0}, 32'h0000_0400, 32'h0,
               32'hDEAD_BEEF, 32'h0000_04FC, 4'b1111, 1'b0, 32'h0, 32'hDEAD_BEEF);
        run_op("R6 store", {5'd0, 4'b1010, 6'h3F, 1'b1}, 32'h0000_0400, 32'h1234_5678,
               32'h0, 32'h0000_04FC, 4'b1111, 1'b1, 32'h1234_5678, 32'h0);
    endtask

    task automatic t_stores;        // R7 R8
        run_op("R7 byte", {5'd0, 4'b0111, 7'd1}, 32'h0000_0010, 32'hAABB_CCDD, 32'h0,
               32'h0000_0011, 4'b0010, 1'b1, 32'hDDDD_DDDD, 32'h0);
        run_op("R7 half", {5'd0, 4'b1001, 7'd1}, 32'h0000_0020, 32'h1122_3344, 32'h0,
               32'h0000_0022, 4'b1100, 1'b1, 32'h3344_3344, 32'h0);
    endtask

    task automatic t_zero_ext_disp; // R1
        run_op("R1", {5'd0, 4'b0110, 7'h7F}, 32'hFFFF_FF00, 32'h0, 32'h0000_0000,
               32'hFFFF_FF7F, 4'b1000, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_illegal;       // R9
        logic [15:0] bad [3] = '{{5'd0, 4'b1111, 7'd0}, 16'h0000, {5'd2, 4'b1011, 7'd9}};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            op_valid = 1'b1; op_word = bad[i]; base_ptr = 32'h40;
            #1;
            chk("R9 illegal_op", 32'(illegal_op), 32'd1);
            chk("R9 mem_req", 32'(mem_req), 32'd0);
            @(negedge clk);
            op_valid = 1'b0;
            chk("R9 ld_valid", 32'(ld_valid), 32'd0);
        end
    endtask

    task automatic t_idle;          // R12
        @(negedge clk);
        op_valid = 1'b0; op_word = {5'd0, 4'b1010, 7'd0}; base_ptr = 32'h80;
        #1;
        chk("R12 mem_req", 32'(mem_req), 32'd0);
        chk("R12 illegal_op", 32'(illegal_op), 32'd0);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_word = '0; base_ptr = '0; st_src = '0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_byte_signed();
        t_byte_unsigned();
        t_half_signed();
        t_half_unsigned();
        t_word();
        t_stores();
        t_zero_ext_disp();
        t_illegal();
        t_idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule